// File: doc/BRIEF.md
# Serial Port Interrupt Enable and Identification

This block gathers the interrupt sources of a serial port into one interrupt line. It also produces the identification code that software reads to find out why that line is high. A 4-bit enable register at offset 1 selects which sources may interrupt. The identification code at offset 2 names the highest-priority source that is both pending and enabled.

Level conditions drive two of the sources directly: receive data ready and receive character timeout. The other three arrive as one-cycle set pulses and are latched here until software clears them:

- line status error, cleared by a read of the line status register;
- transmit holding empty, cleared by a write of the transmit buffer, or by a read of the identification register while it is the reported source;
- modem status change, cleared by a read of the modem status register.

The enclosing port drives the register bus and the latch-access bit. It merges `reg_rdata` with its own registers; this block drives zero at offsets it does not own.

Top module: `uart_irq_ctrl`

## Requirements
- R1: A write at offset 1 with `dlab`=0 stores `reg_wdata[3:0]` into the enable register one cycle later. A write at offset 1 with `dlab`=1 leaves the register unchanged.
- R2: A read at offset 1 with `dlab`=0 returns the enable bits in bits 3:0, and bits 7:4 always read 0.
- R3: Offset 2 returns the 4-bit identification code in bits 3:0, with bits 7:4 zero. Bit 0 is 0 when an interrupt is pending. The codes are: line status 0x6, receive data 0x4, receive timeout 0xC, transmit empty 0x2, modem status 0x0, and none 0x1.
- R4: Priority from highest to lowest is line status, receive data, receive timeout, transmit empty, modem status.
- R5: Enable bit 0 gates receive data and receive timeout. Timeout counts only while `fifo_en`=1.
- R6: Enable bit 1 gates transmit empty. The pending flag clears on a write at offset 0 with `dlab`=0. It also clears on a read at offset 2 while 0x2 is the reported code.
- R7: A read at offset 2 while a higher-priority source is reported leaves transmit empty pending.
- R8: Enable bit 2 gates line status. Its pending flag clears on a read at offset 5.
- R9: Enable bit 3 gates modem status. Its pending flag clears on a read at offset 6.
- R10: A set pulse in the same cycle as its clearing access leaves the flag pending.
- R11: With enable bits all 0, `irq` is 0 and the code is 0x1. Pending flags keep latching and become visible again once their enable bit is set.
- R12: `irq` is 1 exactly when the code's bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle (drives read side effects) |
| reg_wdata | input | 8 | Write data |
| dlab | input | 1 | Latch-access bit from the line control register |
| fifo_en | input | 1 | FIFO mode active |
| rx_avail | input | 1 | Receive data ready (level) |
| rx_timeout | input | 1 | Receive character timeout (level) |
| thr_empty_set | input | 1 | Transmit holding register became empty (pulse) |
| lsr_err_set | input | 1 | Overrun, parity, framing or break seen (pulse) |
| msr_chg_set | input | 1 | A modem status input changed (pulse) |
| reg_rdata | output | 8 | Read data for offsets 1 and 2, zero elsewhere |
| irq | output | 1 | Interrupt output |

## Verification
The assertions take the set pulses and access strobes to be synchronous to `clk` and free of X after reset. They also take a read side effect to happen only on cycles where `reg_rd` is high. The stimulus changes every input one time unit after a rising edge. It holds each strobe for exactly one cycle and never asserts `reg_wr` and `reg_rd` together. As a result, every set/clear collision the bench creates is the deliberate same-cycle case named in R10.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ID_W = 4;

  localparam logic [ID_W-1:0] ID_LINE   = 4'h6;
  localparam logic [ID_W-1:0] ID_RXDATA = 4'h4;
  localparam logic [ID_W-1:0] ID_RXTMO  = 4'hC;
  localparam logic [ID_W-1:0] ID_TXEMPT = 4'h2;
  localparam logic [ID_W-1:0] ID_MODEM  = 4'h0;
  localparam logic [ID_W-1:0] ID_NONE   = 4'h1;

  localparam int OFS_DATA = 0;
  localparam int OFS_IER  = 1;
  localparam int OFS_IIR  = 2;
  localparam int OFS_LSR  = 5;
  localparam int OFS_MSR  = 6;

  // enable bit positions
  localparam int EN_RX  = 0;
  localparam int EN_TX  = 1;
  localparam int EN_LS  = 2;
  localparam int EN_MS  = 3;

  // priority encoder: highest enabled pending source wins
  function automatic logic [ID_W-1:0] pick_id(
    input logic [3:0] en,
    input logic       fifo,
    input logic       rxa,
    input logic       rxt,
    input logic       lsr,
    input logic       thr,
    input logic       msr
  );
    if (en[EN_LS] && lsr)              return ID_LINE;
    else if (en[EN_RX] && rxa)         return ID_RXDATA;
    else if (en[EN_RX] && fifo && rxt) return ID_RXTMO;
    else if (en[EN_TX] && thr)         return ID_TXEMPT;
    else if (en[EN_MS] && msr)         return ID_MODEM;
    else                               return ID_NONE;
  endfunction
endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int AW    = 3,
  parameter int DW    = 8,
  parameter int IER_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             dlab,
  output logic [IER_W-1:0] ier,
  output logic             ier_sel,
  output logic             iir_sel,
  output logic             thr_wr_stb,
  output logic             iir_rd_stb,
  output logic             lsr_rd_stb,
  output logic             msr_rd_stb
);
  logic ier_wr_stb;
  logic data_sel;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata[DW-1:IER_W];

  assign data_sel   = (reg_addr == AW'(OFS_DATA)) && !dlab;
  assign ier_sel    = (reg_addr == AW'(OFS_IER)) && !dlab;
  assign iir_sel    = (reg_addr == AW'(OFS_IIR));
  assign ier_wr_stb = reg_wr && ier_sel;
  assign thr_wr_stb = reg_wr && data_sel;
  assign iir_rd_stb = reg_rd && iir_sel;
  assign lsr_rd_stb = reg_rd && (reg_addr == AW'(OFS_LSR));
  assign msr_rd_stb = reg_rd && (reg_addr == AW'(OFS_MSR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ier <= '0;
    else if (ier_wr_stb) ier <= reg_wdata[IER_W-1:0];
  end

  // R1
  ier_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(OFS_IER) && !dlab) |=> ier == $past(reg_wdata[IER_W-1:0]));

  // R1
  ier_dlab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(OFS_IER) && dlab) |=> $stable(ier));
endmodule

// File: rtl/uart_irq_pend.sv
module uart_irq_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_empty_set,
  input  logic lsr_err_set,
  input  logic msr_chg_set,
  input  logic thr_wr_stb,
  input  logic iir_rd_stb,
  input  logic thr_reported,
  input  logic lsr_rd_stb,
  input  logic msr_rd_stb,
  output logic thr_pend,
  output logic lsr_pend,
  output logic msr_pend
);
  logic thr_clr;
  logic lsr_clr;
  logic msr_clr;

  assign thr_clr = thr_wr_stb || (iir_rd_stb && thr_reported);
  assign lsr_clr = lsr_rd_stb;
  assign msr_clr = msr_rd_stb;

  // a set pulse wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_pend <= 1'b0;
      lsr_pend <= 1'b0;
      msr_pend <= 1'b0;
    end else begin
      thr_pend <= thr_empty_set || (thr_pend && !thr_clr);
      lsr_pend <= lsr_err_set   || (lsr_pend && !lsr_clr);
      msr_pend <= msr_chg_set   || (msr_pend && !msr_clr);
    end
  end

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_err_set || thr_empty_set || msr_chg_set) |=>
      ((lsr_pend || !$past(lsr_err_set)) && (thr_pend || !$past(thr_empty_set))
       && (msr_pend || !$past(msr_chg_set))));

  // R8
  lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd_stb && !lsr_err_set) |=> !lsr_pend);

  // R6
  thr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr_stb && !thr_empty_set) |=> !thr_pend);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int IER_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IER_W-1:0] ier,
  input  logic             fifo_en,
  input  logic             rx_avail,
  input  logic             rx_timeout,
  input  logic             lsr_pend,
  input  logic             thr_pend,
  input  logic             msr_pend,
  output logic [ID_W-1:0]  id_code,
  output logic             thr_reported,
  output logic             irq
);
  assign id_code = pick_id(ier, fifo_en, rx_avail, rx_timeout,
                           lsr_pend, thr_pend, msr_pend);
  assign thr_reported = (id_code == ID_TXEMPT);
  assign irq = ~id_code[0];

  // R11
  all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == '0) |-> (!irq && id_code == ID_NONE));

  // R4
  line_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_pend && ier[EN_LS]) |-> (id_code == ID_LINE));

  // R5
  tmo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en || !ier[EN_RX]) |-> (id_code != ID_RXTMO));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int AW    = 3,
  parameter int DW    = 8,
  parameter int IER_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  input  logic          dlab,
  input  logic          fifo_en,
  input  logic          rx_avail,
  input  logic          rx_timeout,
  input  logic          thr_empty_set,
  input  logic          lsr_err_set,
  input  logic          msr_chg_set,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam int ID_PAD  = DW - ID_W;
  localparam int IER_PAD = DW - IER_W;

  logic [IER_W-1:0] ier;
  logic             ier_sel, iir_sel;
  logic             thr_wr_stb, iir_rd_stb, lsr_rd_stb, msr_rd_stb;
  logic             thr_pend, lsr_pend, msr_pend;
  logic             thr_reported;
  logic [ID_W-1:0]  id_code;

  uart_irq_regs #(.AW(AW), .DW(DW), .IER_W(IER_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .dlab(dlab), .ier(ier),
    .ier_sel(ier_sel), .iir_sel(iir_sel), .thr_wr_stb(thr_wr_stb),
    .iir_rd_stb(iir_rd_stb), .lsr_rd_stb(lsr_rd_stb), .msr_rd_stb(msr_rd_stb)
  );

  uart_irq_pend u_pend (
    .clk(clk), .rst_n(rst_n), .thr_empty_set(thr_empty_set),
    .lsr_err_set(lsr_err_set), .msr_chg_set(msr_chg_set),
    .thr_wr_stb(thr_wr_stb), .iir_rd_stb(iir_rd_stb),
    .thr_reported(thr_reported), .lsr_rd_stb(lsr_rd_stb),
    .msr_rd_stb(msr_rd_stb), .thr_pend(thr_pend), .lsr_pend(lsr_pend),
    .msr_pend(msr_pend)
  );

  uart_irq_prio #(.IER_W(IER_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .ier(ier), .fifo_en(fifo_en),
    .rx_avail(rx_avail), .rx_timeout(rx_timeout), .lsr_pend(lsr_pend),
    .thr_pend(thr_pend), .msr_pend(msr_pend), .id_code(id_code),
    .thr_reported(thr_reported), .irq(irq)
  );

  always_comb begin
    if (ier_sel)      reg_rdata = {{IER_PAD{1'b0}}, ier};
    else if (iir_sel) reg_rdata = {{ID_PAD{1'b0}}, id_code};
    else              reg_rdata = '0;
  end

  // R2
  ier_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ier_sel |-> (reg_rdata[DW-1:IER_W] == '0));

  // R12
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iir_sel |-> (irq == !reg_rdata[0]));
endmodule

// File: tb/uart_irq_ctrl_bench.sv
`timescale 1ns/100ps
module uart_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       dlab = 1'b0, fifo_en = 1'b0;
  logic       rx_avail = 1'b0, rx_timeout = 1'b0;
  logic       thr_empty_set = 1'b0, lsr_err_set = 1'b0, msr_chg_set = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl u_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .dlab(dlab), .fifo_en(fifo_en),
    .rx_avail(rx_avail), .rx_timeout(rx_timeout),
    .thr_empty_set(thr_empty_set), .lsr_err_set(lsr_err_set),
    .msr_chg_set(msr_chg_set), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {ier[3:0], fifo, rxa, rxt, lsr, thr, msr, 2'b00, expected code[3:0]}
  localparam logic [15:0] VEC [0:13] = '{
    16'b1111_0_0_0_0_0_0_00_0001,  // R3 none
    16'b1111_0_1_0_1_1_1_00_0110,  // R4 line over all
    16'b1111_0_1_0_0_1_1_00_0100,  // R4 rx data over tx/modem
    16'b1111_1_0_1_0_1_0_00_1100,  // R5 timeout in FIFO mode
    16'b1111_0_0_1_0_0_0_00_0001,  // R5 timeout ignored without FIFO
    16'b1111_0_0_0_0_1_1_00_0010,  // R4 tx over modem
    16'b1111_0_0_0_0_0_1_00_0000,  // R9 modem alone
    16'b0000_1_1_1_1_1_1_00_0001,  // R11 all disabled
    16'b1011_0_1_0_1_0_0_00_0100,  // R8 line masked
    16'b1000_0_0_0_1_1_1_00_0000,  // R9 only modem enabled
    16'b0010_0_1_0_0_1_0_00_0010,  // R6 only tx enabled
    16'b0001_1_1_1_0_0_0_00_0100,  // R4 data over timeout
    16'b0100_0_0_0_1_0_0_00_0110,  // R8 line alone
    16'b0001_1_0_1_0_0_0_00_1100   // R5 timeout alone
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic dl);
    reg_addr = a; reg_wdata = d; dlab = dl; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0; dlab = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    reg_addr = a; reg_rd = 1'b1;
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic l, input logic t, input logic m);
    lsr_err_set = l; thr_empty_set = t; msr_chg_set = m;
    tick();
    lsr_err_set = 1'b0; thr_empty_set = 1'b0; msr_chg_set = 1'b0;
  endtask

  task automatic peek_id(input string req, input logic [3:0] exp);
    reg_addr = 3'd2; #1;
    check(req, reg_rdata, {4'h0, exp});
    check(req, {7'd0, irq}, {7'd0, ~exp[0]});
  endtask

  task automatic scrub();
    rx_avail = 1'b0; rx_timeout = 1'b0; fifo_en = 1'b0;
    rd(3'd5); rd(3'd6); wr(3'd0, 8'h00, 1'b0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // reset state: R2 enable reads 0, R3 code none, R12 irq low
    reg_addr = 3'd1; #1;
    check("R2 reset ier", reg_rdata, 8'h00);
    peek_id("R3 reset id", 4'h1);

    // R1 / R2 write all ones, upper bits read 0
    wr(3'd1, 8'hFF, 1'b0);
    reg_addr = 3'd1; #1;
    check("R2 ier upper zero", reg_rdata, 8'h0F);
    // R1 write with dlab set ignored
    wr(3'd1, 8'h00, 1'b1);
    reg_addr = 3'd1; #1;
    check("R1 dlab write ignored", reg_rdata, 8'h0F);

    for (int i = 0; i < 14; i++) begin
      logic [15:0] v;
      v = VEC[i];
      wr(3'd1, {4'h0, v[15:12]}, 1'b0);
      pulse(v[8], v[7], v[6]);
      fifo_en = v[11]; rx_avail = v[10]; rx_timeout = v[9];
      peek_id($sformatf("R4 vector %0d", i), v[3:0]);
      scrub();
    end

    // R6 tx cleared by id read while reported
    wr(3'd1, 8'h02, 1'b0);
    pulse(1'b0, 1'b1, 1'b0);
    peek_id("R6 tx pending", 4'h2);
    rd(3'd2);
    peek_id("R6 cleared by id read", 4'h1);

    // R7 id read with line reported leaves tx pending
    wr(3'd1, 8'h06, 1'b0);
    pulse(1'b1, 1'b1, 1'b0);
    rd(3'd2);
    peek_id("R7 line still top", 4'h6);
    rd(3'd5);
    peek_id("R7 tx survived id read", 4'h2);
    wr(3'd0, 8'h55, 1'b0);
    peek_id("R6 cleared by tx write", 4'h1);

    // R9 modem set and cleared
    wr(3'd1, 8'h08, 1'b0);
    pulse(1'b0, 1'b0, 1'b1);
    peek_id("R9 modem pending", 4'h0);
    rd(3'd6);
    peek_id("R9 modem cleared", 4'h1);

    // R10 set and clear in the same cycle
    wr(3'd1, 8'h04, 1'b0);
    lsr_err_set = 1'b1;
    rd(3'd5);
    lsr_err_set = 1'b0;
    peek_id("R10 set wins", 4'h6);
    rd(3'd5);
    peek_id("R8 line cleared", 4'h1);

    // R11 latched while disabled, visible after enable
    wr(3'd1, 8'h00, 1'b0);
    pulse(1'b1, 1'b0, 1'b0);
    peek_id("R11 disabled hides", 4'h1);
    wr(3'd1, 8'h04, 1'b0);
    peek_id("R11 re-enable shows", 4'h6);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule